// File: doc/BRIEF.md
# Program Memory Access Guard

This block decides where each program-memory request goes and whether it may be served. Requests are opcode or operand fetches, table reads issued by the CPU, and reads from a test-mode port. Each request is routed either to the on-chip code ROM or to external program memory. The choice depends on the address and on an external-access strap pin. The block captures that pin only while reset is held and disregards it for the rest of operation. As a result, a running program cannot move an address window from external to internal memory in the middle of an instruction.

A static security input guards the on-chip ROM against being read out. When it is set, a table read issued by code that runs from external memory may not return on-chip ROM contents, and neither may a test-port read. A refused request is answered with a grant of zero and a mask flag that tells the data path to return all-ones. A single-cycle violation flag accompanies the refusal. Each answer appears one clock after its request.

Top module: `pmem_guard`

## Requirements
- R1: While `rst` is high, the block samples `ext_only_pin` every clock. If the value held at reset release is 1, every request after reset routes external (`rsp_sel_int` = 0).
- R2: After reset is released, changes on `ext_only_pin` have no effect on routing.
- R3: With the internal option latched (pin 0 at reset release), an address below `ROM_SIZE` (default 0x2000) routes internal (`rsp_sel_int` = 1), and any address at or above it routes external.
- R4: A fetch (`req_kind` = 2'b00) is always granted and never masked, whatever the address, the security input or the location of the executing code.
- R5: A table read (`req_kind` = 2'b01) that routes internal is refused when `secure_en` = 1 and `req_from_ext` = 1.
- R6: A table read is granted when it routes external, when `secure_en` = 0, or when the executing code is internal (`req_from_ext` = 0).
- R7: A test read (`req_kind` = 2'b10) that routes internal is refused when `secure_en` = 1, whatever `req_from_ext` is. A test read that routes external is granted.
- R8: A refused request answers with `rsp_grant` = 0, `rsp_mask_ones` = 1 and `rsp_violation` = 1. The violation flag lasts only for that response cycle.
- R9: The reserved kind 2'b11 answers with `rsp_grant` = 0, `rsp_mask_ones` = 1 and `rsp_violation` = 0.
- R10: The answer appears on the clock after the request. In a cycle with no request, and throughout reset, `rsp_valid`, `rsp_grant`, `rsp_mask_ones`, `rsp_violation` and `rsp_sel_int` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset; the strap pin is captured while it is high |
| ext_only_pin | input | 1 | Strap: 1 forces all program memory external |
| secure_en | input | 1 | Static security setting for the on-chip ROM |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 fetch, 01 table read, 10 test read, 11 reserved |
| req_addr | input | ADDR_W | Program-memory address |
| req_from_ext | input | 1 | Executing instruction was fetched from external memory |
| rsp_valid | output | 1 | Answer present |
| rsp_sel_int | output | 1 | Request routes to on-chip ROM |
| rsp_grant | output | 1 | Access allowed |
| rsp_mask_ones | output | 1 | Data path must return all-ones |
| rsp_violation | output | 1 | One-cycle flag for a refused secure access |

## Verification
The assertions assume that `secure_en` and `req_from_ext` are stable during the cycle a request is sampled. They also assume that `req_kind` carries one of its four encodings whenever `req_valid` is high. The stimulus changes the security input only while no request is pending, and it drives every request input at the falling edge. Reset is always held long enough to cover a rising edge, so the strap pin is captured.

// File: rtl/pmem_guard_pkg.sv
package pmem_guard_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_TABLE = 2'b01,
        KIND_TEST  = 2'b10,
        KIND_RSVD  = 2'b11
    } req_kind_e;

    typedef struct packed {
        logic valid;
        logic sel_int;
        logic grant;
        logic mask_ones;
        logic violation;
    } rsp_t;

endpackage

// File: rtl/pmem_strap_latch.sv
module pmem_strap_latch (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic ext_only
);
    logic strap_d;
    logic strap_q;

    always_comb begin
        strap_d = strap_q;
        if (rst) begin
            strap_d = pin;
        end
    end

    always_ff @(posedge clk) begin
        strap_q <= strap_d;
    end

    assign ext_only = strap_q;
endmodule

// File: rtl/pmem_region_decode.sv
module pmem_region_decode #(
    parameter int ADDR_W   = 16,
    parameter int ROM_SIZE = 8192
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_only,
    output logic              route_int
);
    localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(ROM_SIZE);
    localparam bool_full = (ROM_SIZE >= (1 << ADDR_W));

    logic in_rom;

    generate
        if (bool_full) begin : g_full
            assign in_rom = 1'b1;
        end else begin : g_part
            assign in_rom = ({1'b0, addr} < ROM_LIM);
        end
    endgenerate

    assign route_int = in_rom && !ext_only;
endmodule

// File: rtl/pmem_access_policy.sv
module pmem_access_policy
    import pmem_guard_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       route_int,
    input  logic       secure,
    input  logic       from_ext,
    output logic       grant,
    output logic       mask_ones,
    output logic       violation
);
    logic protect;

    always_comb begin
        protect   = 1'b0;
        grant     = 1'b1;
        mask_ones = 1'b0;
        violation = 1'b0;
        case (req_kind_e'(kind))
            KIND_FETCH: protect = 1'b0;
            KIND_TABLE: protect = route_int && secure && from_ext;
            KIND_TEST:  protect = route_int && secure;
            default: begin
                grant     = 1'b0;
                mask_ones = 1'b1;
            end
        endcase
        if (protect) begin
            grant     = 1'b0;
            mask_ones = 1'b1;
            violation = 1'b1;
        end
    end
endmodule

// File: rtl/pmem_guard.sv
module pmem_guard
    import pmem_guard_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ROM_SIZE = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_only_pin,
    input  logic              secure_en,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_from_ext,
    output logic              rsp_valid,
    output logic              rsp_sel_int,
    output logic              rsp_grant,
    output logic              rsp_mask_ones,
    output logic              rsp_violation
);
    logic ext_only;
    logic route_int;
    logic pol_grant;
    logic pol_mask;
    logic pol_viol;
    rsp_t rsp_d;
    rsp_t rsp_q;

    pmem_strap_latch u_strap (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_only_pin),
        .ext_only (ext_only)
    );

    pmem_region_decode #(
        .ADDR_W   (ADDR_W),
        .ROM_SIZE (ROM_SIZE)
    ) u_region (
        .addr      (req_addr),
        .ext_only  (ext_only),
        .route_int (route_int)
    );

    pmem_access_policy u_policy (
        .kind      (req_kind),
        .route_int (route_int),
        .secure    (secure_en),
        .from_ext  (req_from_ext),
        .grant     (pol_grant),
        .mask_ones (pol_mask),
        .violation (pol_viol)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid     = 1'b1;
            rsp_d.sel_int   = route_int;
            rsp_d.grant     = pol_grant;
            rsp_d.mask_ones = pol_mask;
            rsp_d.violation = pol_viol;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_sel_int   = rsp_q.sel_int;
    assign rsp_grant     = rsp_q.grant;
    assign rsp_mask_ones = rsp_q.mask_ones;
    assign rsp_violation = rsp_q.violation;
endmodule

// File: rtl/pmem_guard_chk.sv
module pmem_guard_chk #(
    parameter int ADDR_W   = 16,
    parameter int ROM_SIZE = 8192
) (
    input logic              clk,
    input logic              rst,
    input logic              secure_en,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_from_ext,
    input logic              rsp_valid,
    input logic              rsp_sel_int,
    input logic              rsp_grant,
    input logic              rsp_mask_ones,
    input logic              rsp_violation
);
    localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(ROM_SIZE);

    assert_high_addr_external_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ({1'b0, req_addr} >= ROM_LIM)) |=> !rsp_sel_int);

    assert_fetch_granted_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b00) |=> (rsp_grant && !rsp_mask_ones));

    assert_table_guard_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b01 && secure_en && req_from_ext)
            |=> !(rsp_grant && rsp_sel_int));

    assert_test_guard_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b10 && secure_en) |=> !(rsp_grant && rsp_sel_int));

    assert_violation_masks_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_violation |-> (rsp_mask_ones && !rsp_grant));

    assert_reserved_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b11) |=> (!rsp_grant && rsp_mask_ones && !rsp_violation));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_grant || rsp_mask_ones || rsp_violation || rsp_sel_int));

    assert_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
endmodule

bind pmem_guard pmem_guard_chk #(
    .ADDR_W   (ADDR_W),
    .ROM_SIZE (ROM_SIZE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .secure_en     (secure_en),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_addr      (req_addr),
    .req_from_ext  (req_from_ext),
    .rsp_valid     (rsp_valid),
    .rsp_sel_int   (rsp_sel_int),
    .rsp_grant     (rsp_grant),
    .rsp_mask_ones (rsp_mask_ones),
    .rsp_violation (rsp_violation)
);

// File: tb/test_pmem_guard.sv
`timescale 1ns/1ps
module test_pmem_guard;
    localparam int ADDR_W = 16;
    localparam int NVEC   = 12;

    // Vector: [23:22] kind, [21:6] addr, [5] from_ext, [4] secure,
    //         [3:0] expected {grant, sel_int, mask_ones, violation}
    localparam logic [23:0] VEC [NVEC] = '{
        {2'b00, 16'h0100, 1'b0, 1'b0, 4'b1100},  // R3 R4 internal fetch
        {2'b00, 16'h4000, 1'b0, 1'b0, 4'b1000},  // R3 R4 external fetch
        {2'b01, 16'h0100, 1'b1, 1'b1, 4'b0111},  // R5 R8 blocked table read
        {2'b01, 16'h0100, 1'b0, 1'b1, 4'b1100},  // R6 internal code
        {2'b01, 16'h0100, 1'b1, 1'b0, 4'b1100},  // R6 security off
        {2'b01, 16'h1FFF, 1'b1, 1'b1, 4'b0111},  // R5 last ROM address
        {2'b01, 16'h2000, 1'b1, 1'b1, 4'b1000},  // R6 first external address
        {2'b10, 16'h0000, 1'b0, 1'b1, 4'b0111},  // R7 test read blocked
        {2'b10, 16'h0000, 1'b0, 1'b0, 4'b1100},  // R7 test read open
        {2'b10, 16'h8000, 1'b1, 1'b1, 4'b1000},  // R7 test read external
        {2'b00, 16'h0100, 1'b1, 1'b1, 4'b1100},  // R4 fetch never masked
        {2'b11, 16'h0100, 1'b0, 1'b1, 4'b0110}   // R9 reserved kind
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ext_only_pin = 1'b0;
    logic              secure_en = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_from_ext = 1'b0;
    logic              rsp_valid;
    logic              rsp_sel_int;
    logic              rsp_grant;
    logic              rsp_mask_ones;
    logic              rsp_violation;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    pmem_guard #(.ADDR_W(ADDR_W), .ROM_SIZE(8192)) i_pmem_guard (
        .clk           (clk),
        .rst           (rst),
        .ext_only_pin  (ext_only_pin),
        .secure_en     (secure_en),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_addr      (req_addr),
        .req_from_ext  (req_from_ext),
        .rsp_valid     (rsp_valid),
        .rsp_sel_int   (rsp_sel_int),
        .rsp_grant     (rsp_grant),
        .rsp_mask_ones (rsp_mask_ones),
        .rsp_violation (rsp_violation)
    );

    function automatic string tag_of(input logic [1:0] kind, input logic [3:0] exp);
        if (kind == 2'b11) return "R9";
        if (kind == 2'b00) return "R4";
        if (kind == 2'b10) return "R7";
        if (exp[0])        return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,grant,sel,mask,viol} actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {rsp_valid, rsp_grant, rsp_sel_int, rsp_mask_ones, rsp_violation};
    endfunction

    // Drive at falling edge; answer is registered at next rising edge; sample at the falling edge after.
    task automatic issue(input logic [1:0] kind, input logic [15:0] addr,
                         input logic from_ext, input logic sec);
        @(negedge clk);
        secure_en    = sec;
        req_valid    = 1'b1;
        req_kind     = kind;
        req_addr     = addr;
        req_from_ext = from_ext;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1'b1;
        ext_only_pin = pin;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        ext_only_pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 reset state", outs(), 5'b00000);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][23:22], VEC[i][21:6], VEC[i][5], VEC[i][4]);
            check(tag_of(VEC[i][23:22], VEC[i][3:0]), outs(), {1'b1, VEC[i][3:0]});
        end

        // R8 violation lasts one cycle; R10 idle cycle is quiet
        issue(2'b10, 16'h0010, 1'b0, 1'b1);
        check("R8 pulse", outs(), 5'b10111);
        @(negedge clk);
        check("R8 pulse ends / R10 idle", outs(), 5'b00000);

        // R2: pin toggled after reset does not change routing
        @(negedge clk);
        ext_only_pin = 1'b1;
        issue(2'b00, 16'h0100, 1'b0, 1'b0);
        check("R2 pin ignored", outs(), 5'b11100);
        issue(2'b01, 16'h0100, 1'b1, 1'b1);
        check("R2 guard stays", outs(), 5'b10111);

        // R1: pin high at reset release sends everything external
        do_reset(1'b1);
        check("R10 after reset", outs(), 5'b00000);
        ext_only_pin = 1'b0;
        issue(2'b00, 16'h0100, 1'b0, 1'b1);
        check("R1 fetch external", outs(), 5'b11000);
        issue(2'b01, 16'h0000, 1'b1, 1'b1);
        check("R1 table read external", outs(), 5'b11000);
        issue(2'b10, 16'h0000, 1'b0, 1'b1);
        check("R1 test read external", outs(), 5'b11000);

        // R1: pin sampled at end of reset, low again
        do_reset(1'b0);
        ext_only_pin = 1'b1;
        issue(2'b00, 16'h1FFF, 1'b0, 1'b0);
        check("R1 relatch internal", outs(), 5'b11100);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule